// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one read or write burst of a synchronous DRAM. The controller gives it a start strobe together with an 8-bit starting column, a 3-bit burst-length code and an ordering bit. Starting on the next clock, the block puts out one column per cycle with a valid flag. A last-beat flag marks the final column of every fixed-length burst.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned block of the burst length. In full-page mode that block is the whole 256-column page. Interleave ordering XORs the low column bits of the start address with the beat index. A full-page burst runs until the terminate input is asserted, and terminate also cuts short any fixed burst. A request whose code, or whose code and ordering together, is not supported raises a one-cycle error flag and produces no beats.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `valid`, `last` and `err` are all low.
- R2: A legal start sampled at a clock edge drives beat 0 (the start column) with `valid` high in the following cycle. After that the block produces exactly one beat per clock until the burst ends.
- R3: In sequential ordering (`ilv`=0) with burst length L of 1, 2, 4 or 8, beat k (k < L) is (n with its low log2(L) bits cleared) plus ((n + k) mod L), where n is the start column.
- R4: In sequential full-page mode, beat k is (n + k) mod 256. The beats continue without end and `last` is never asserted.
- R5: In interleave ordering (`ilv`=1) with L = 4 or 8, beat k (k < L) is n XOR k. The column bits above the low log2(L) bits stay constant for the whole burst.
- R6: The length codes are 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. Setting `ilv`=0 selects sequential ordering and `ilv`=1 selects interleave ordering.
- R7: A start is rejected when its code is 3'b100, 3'b101 or 3'b110, or when `ilv`=1 with any code other than 3'b010 or 3'b011. A rejected start sets `err` high for exactly the following cycle and produces no beat. It also ends any burst that is in progress.
- R8: `last` is high together with beat L-1 of every fixed-length burst. `valid` is low in the next cycle unless a new start was sampled.
- R9: A terminate sampled without a start ends the burst, so `valid` is low in the following cycle.
- R10: A start sampled during an active burst restarts the sequence from the new column in the following cycle. When start and terminate are sampled together, the start wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | 8 | Starting column address |
| len_code | input | 3 | Burst length code |
| ilv | input | 1 | Ordering: 0 sequential, 1 interleave |
| term | input | 1 | End the current burst |
| col | output | 8 | Column address of the current beat |
| valid | output | 1 | A beat is present on `col` |
| last | output | 1 | Final beat of a fixed-length burst |
| err | output | 1 | The previous start request was rejected |

## Verification
The embedded properties assume that `start`, `term` and the request fields never carry unknown values after reset. They also assume that a full-page run can only be stopped by `term`, a new start or reset. The stimulus meets these assumptions by driving every input to a defined value from time zero. Inputs change only on the falling edge, so every rising edge samples a settled request. Bursts are started from columns near the page end (for example 8'hFD and 8'hFE), so that block-local and full-page wrap are both exercised.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             term,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             err
);

  logic             active_q, ilv_q, full_q, err_q;
  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic [COL_W-1:0] mask_d;
  logic             legal, full_d;

  always_comb begin
    mask_d = '0;
    full_d = 1'b0;
    case (len_code)
      3'b000: mask_d = COL_W'(0);
      3'b001: mask_d = COL_W'(1);
      3'b010: mask_d = COL_W'(3);
      3'b011: mask_d = COL_W'(7);
      3'b111: begin mask_d = '1; full_d = 1'b1; end
      default: mask_d = '0;
    endcase
  end

  assign legal = ilv ? (len_code == 3'b010 || len_code == 3'b011)
                     : (len_code[2] == 1'b0 || len_code == 3'b111);

  assign valid = active_q;
  assign err   = err_q;
  assign last  = active_q && !full_q && (beat_q == mask_q);
  assign col   = ilv_q ? (base_q ^ beat_q)
                       : ((base_q & ~mask_q) | ((base_q + beat_q) & mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      beat_q   <= '0;
    end else begin
      err_q <= 1'b0;
      if (start) begin
        active_q <= legal;
        err_q    <= !legal;
        ilv_q    <= ilv;
        full_q   <= full_d;
        base_q   <= start_col;
        mask_q   <= mask_d;
        beat_q   <= '0;
      end else if (term || last) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!valid && !last && !err));

  assert_full_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full_q && !ilv_q && !start && !term) |=> (valid && col == $past(col) + 1'b1));

  assert_full_no_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full_q) |-> !last);

  assert_ilv_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ilv_q && !start && !term && !last) |=> (col[COL_W-1:3] == $past(col[COL_W-1:3])));

  assert_err_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !valid);

  assert_term_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !start) |=> !valid);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ilv && len_code == 3'b111) |=> (valid && col == $past(start_col)));

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = 8'h00;
  logic [2:0] len_code = 3'b000;
  logic       ilv = 1'b0;
  logic       term = 1'b0;
  logic [7:0] col;
  logic       valid, last, err;

  int errors = 0;
  int checks = 0;
  string req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .term(term),
    .col(col), .valid(valid), .last(last), .err(err)
  );

  // reference model
  int m_active = 0, m_k = 0, m_base = 0, m_len = 1, m_ilv = 0, m_err = 0;

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    int l;
    if (!rst_n) begin
      m_active = 0; m_err = 0; m_k = 0;
    end else begin
      m_err = 0;
      if (start) begin
        l = code_len(len_code);
        if (l < 0 || (ilv && l != 4 && l != 8)) begin
          m_active = 0; m_err = 1;
        end else begin
          m_active = 1; m_k = 0; m_base = start_col; m_len = l; m_ilv = ilv;
        end
      end else if (term) begin
        m_active = 0;
      end else if (m_active == 1) begin
        if (m_len != 0 && m_k == m_len - 1) m_active = 0;
        else m_k = (m_k + 1) % 256;
      end
    end
  end

  function automatic int exp_col();
    if (m_ilv == 1) return m_base ^ m_k;
    if (m_len == 0) return (m_base + m_k) % 256;
    return (m_base / m_len) * m_len + (m_base + m_k) % m_len;
  endfunction

  always @(negedge clk) begin
    int ev, el, ec;
    if (!done) begin
      ev = m_active;
      el = (m_active == 1 && m_len != 0 && m_k == m_len - 1) ? 1 : 0;
      ec = exp_col();
      checks++;
      if (valid !== ev[0] || last !== el[0] || err !== m_err[0] ||
          (ev == 1 && col !== ec[7:0])) begin
        errors++;
        $display("FAIL %s: got valid=%0b last=%0b err=%0b col=%02h, expected valid=%0d last=%0d err=%0d col=%02h",
                 req, valid, last, err, col, ev, el, m_err, ec[7:0]);
      end
    end
  end

  task automatic go(input logic [7:0] c, input logic [2:0] code, input logic mode);
    @(negedge clk); #1;
    start = 1'b1; start_col = c; len_code = code; ilv = mode;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_now();
    @(negedge clk); #1; term = 1'b1;
    @(negedge clk); #1; term = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    req = "R1"; idle(3);
    #1 rst_n = 1'b1;
    idle(2);
    req = "R2/R3 len2"; go(8'h35, 3'b001, 1'b0); idle(3);
    req = "R3 len4";    go(8'hFE, 3'b010, 1'b0); idle(5);
    req = "R3 len8";    go(8'h1D, 3'b011, 1'b0); idle(9);
    req = "R3 len1";    go(8'h77, 3'b000, 1'b0); idle(2);
    req = "R8 last";    go(8'h0B, 3'b011, 1'b0); idle(9);
    req = "R4 fullpage"; go(8'hFD, 3'b111, 1'b0); idle(12);
    req = "R9 term";    stop_now(); idle(2);
    req = "R4 long";    go(8'h10, 3'b111, 1'b0); idle(300); stop_now(); idle(2);
    req = "R5 ilv4";    go(8'hA6, 3'b010, 1'b1); idle(5);
    req = "R5 ilv8";    go(8'h5B, 3'b011, 1'b1); idle(9);
    req = "R6 codes";   go(8'hC3, 3'b011, 1'b1); idle(2); go(8'hC3, 3'b011, 1'b0); idle(9);
    req = "R7 code100"; go(8'h20, 3'b100, 1'b0); idle(2);
    req = "R7 code110"; go(8'h20, 3'b110, 1'b0); idle(2);
    req = "R7 ilv len2"; go(8'h20, 3'b001, 1'b1); idle(2);
    req = "R7 ilv full"; go(8'h20, 3'b111, 1'b1); idle(2);
    req = "R7 abort";   go(8'h40, 3'b111, 1'b0); idle(3); go(8'h40, 3'b101, 1'b0); idle(3);
    req = "R9 midburst"; go(8'h60, 3'b011, 1'b0); idle(2); stop_now(); idle(3);
    req = "R10 restart"; go(8'h80, 3'b011, 1'b0); idle(3); go(8'h93, 3'b010, 1'b1); idle(5);
    req = "R10 priority";
    go(8'hE0, 3'b111, 1'b0); idle(2);
    @(negedge clk); #1; start = 1'b1; term = 1'b1; start_col = 8'h07; len_code = 3'b001; ilv = 1'b0;
    @(negedge clk); #1; start = 1'b0; term = 1'b0;
    idle(4);
    req = "R1 reset";
    go(8'h11, 3'b111, 1'b0); idle(2);
    @(negedge clk); #1 rst_n = 1'b0; idle(2); #1 rst_n = 1'b1; idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule